// File: doc/BRIEF.md
# Duty-Cycled Wake Controller with Pulse-Width Qualification

This block decides when a low-power on-off-keyed receiver is worth keeping awake. With the duty-cycle feature turned on, it alternates between two states. In the sleeping state only a slow tick is counted and the analog chain is asked to power down. In the polling state the analog chain is powered and the widths of the raw demodulated pulses are measured on a sampling clock. Marks and spaces are both measured. Each pulse is graded against a window whose length depends on a window code and on the demodulator bandwidth code.

While the block sleeps or polls, the data output is held low. After a programmed number of consecutive long pulses, the block moves to continuous receive. From then on the raw data reaches the output, and the block stays there until the configuration is written again. A run of four short pulses sends the block back to sleep. With the duty-cycle feature turned off, the block stays in continuous receive.

`raw_data` is assumed to be synchronous to `clk`. A pulse width is the number of `clk` cycles between two consecutive changes of `raw_data`. The sleep tick is a one-cycle strobe on `clk`.

Top module: `poll_wake_checker`

## Requirements
- R1: After reset the duty-cycle feature is off. While it is off, the block is in continuous receive: `st_rx`=1, `power_req`=1 and `data_out` equals `raw_data`, and sleep ticks change nothing.
- R2: A configuration write with `cfg_poll_en`=1 enters sleep. Sleep lasts 2^`cfg_sleep_code` sleep ticks, and polling starts on the edge that samples the last of those ticks. `power_req` is 0 only during sleep.
- R3: The window in `clk` cycles is (WIN_BASE − `cfg_win_code`·WIN_STEP) >> `cfg_bw_code`. Code 0 gives the longest window and code 7 the shortest. Each step up in the bandwidth code halves the window. A pulse is valid only if its width is strictly greater than the window; a width equal to the window is bad.
- R4: `data_out` is 0 during sleep and during polling, whatever `raw_data` does.
- R5: Four consecutive bad pulses during polling return the block to sleep.
- R6: `cfg_run_code` values 0, 1, 2 and 3 require 0, 4, 8 and 16 consecutive valid pulses. When the count is reached the block enters continuous receive. With code 0 the block goes from sleep straight to continuous receive.
- R7: Continuous receive is sticky. The block stays there with `data_out` equal to `raw_data` even when the input is idle for a long time.
- R8: A valid pulse clears the run of bad pulses, and a bad pulse clears the run of valid pulses.
- R9: A configuration write loads all fields and restarts the block: into sleep if `cfg_poll_en`=1, otherwise into continuous receive.
- R10: The first change of `raw_data` after polling starts only begins a measurement. The partial pulse before that change is never graded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| sleep_tick | input | 1 | One-cycle strobe marking one sleep time unit |
| cfg_wr | input | 1 | Configuration load and restart strobe |
| cfg_poll_en | input | 1 | 1 enables duty-cycled polling |
| cfg_sleep_code | input | 3 | Sleep length code, 2^code ticks |
| cfg_win_code | input | 3 | Window length code, 0 longest |
| cfg_bw_code | input | 2 | Demodulator bandwidth code, each step halves the window |
| cfg_run_code | input | 2 | Required valid run: 0, 4, 8, 16 |
| raw_data | input | 1 | Raw demodulated data |
| data_out | output | 1 | Gated data output |
| power_req | output | 1 | Power request for the analog chain |
| st_sleep | output | 1 | Block is sleeping |
| st_poll | output | 1 | Block is polling |
| st_rx | output | 1 | Block is in continuous receive |

## Verification
The bench sends pulses exactly one cycle longer than the window and pulses exactly equal to it, at two different bandwidth codes. A design with an inclusive compare or a wrong shift would release on the equal-width pulses or would fall asleep on the long ones. Runs are broken in the middle, valid by bad and bad by valid. A design that failed to clear the opposite run would release or sleep one pulse too early. Three short pulses right after wake-up must leave the block polling, which catches a design that grades the partial pulse before the first edge. Sleep length is checked one tick before and at the terminal tick, and continuous receive is held through a long idle stretch to catch a design that drops back to sleep when the signal goes away.

// File: rtl/poll_wake_checker.sv
module poll_wake_checker #(
  parameter int WIN_BASE  = 60,
  parameter int WIN_STEP  = 4,
  parameter int BAD_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_tick,
  input  logic       cfg_wr,
  input  logic       cfg_poll_en,
  input  logic [2:0] cfg_sleep_code,
  input  logic [2:0] cfg_win_code,
  input  logic [1:0] cfg_bw_code,
  input  logic [1:0] cfg_run_code,
  input  logic       raw_data,
  output logic       data_out,
  output logic       power_req,
  output logic       st_sleep,
  output logic       st_poll,
  output logic       st_rx
);
  localparam int WCW = $clog2(WIN_BASE + 2);
  localparam int BCW = $clog2(BAD_LIMIT + 1);

  typedef enum logic [1:0] {S_RX = 2'd0, S_SLEEP = 2'd1, S_POLL = 2'd2} st_t;

  st_t            state;
  logic           poll_en_q;
  logic [2:0]     sleep_code_q, win_code_q;
  logic [1:0]     bw_code_q, run_code_q;
  logic           raw_q, armed;
  logic [WCW-1:0] width, win_lim;
  logic [4:0]     good_run, need;
  logic [BCW-1:0] bad_run;
  logic [7:0]     sl_cnt;
  int             win_full;

  always_comb begin
    win_full = (WIN_BASE - int'(win_code_q) * WIN_STEP) >>> bw_code_q;
    win_lim  = win_full[WCW-1:0];
    case (run_code_q)
      2'd1:    need = 5'd4;
      2'd2:    need = 5'd8;
      2'd3:    need = 5'd16;
      default: need = 5'd0;
    endcase
  end

  wire edge_seen  = raw_data ^ raw_q;
  wire is_long    = width > win_lim;
  wire sleep_last = sl_cnt == ((8'd1 << sleep_code_q) - 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_RX;
      poll_en_q    <= 1'b0;
      sleep_code_q <= 3'd2;
      win_code_q   <= 3'd7;
      bw_code_q    <= 2'd3;
      run_code_q   <= 2'd0;
      raw_q        <= 1'b0;
      armed        <= 1'b0;
      width        <= '0;
      good_run     <= '0;
      bad_run      <= '0;
      sl_cnt       <= '0;
    end else begin
      raw_q <= raw_data;
      if (cfg_wr) begin
        poll_en_q    <= cfg_poll_en;
        sleep_code_q <= cfg_sleep_code;
        win_code_q   <= cfg_win_code;
        bw_code_q    <= cfg_bw_code;
        run_code_q   <= cfg_run_code;
        state        <= cfg_poll_en ? S_SLEEP : S_RX;
        sl_cnt       <= '0;
        armed        <= 1'b0;
        width        <= '0;
        good_run     <= '0;
        bad_run      <= '0;
      end else begin
        case (state)
          S_SLEEP: if (sleep_tick) begin
            if (sleep_last) begin
              sl_cnt   <= '0;
              state    <= (need == 5'd0) ? S_RX : S_POLL;
              armed    <= 1'b0;
              width    <= '0;
              good_run <= '0;
              bad_run  <= '0;
            end else begin
              sl_cnt <= sl_cnt + 8'd1;
            end
          end
          S_POLL: begin
            if (edge_seen) begin
              armed <= 1'b1;
              width <= WCW'(1);
              if (armed) begin
                if (is_long) begin
                  bad_run <= '0;
                  if (good_run + 5'd1 == need) state <= S_RX;
                  else good_run <= good_run + 5'd1;
                end else begin
                  good_run <= '0;
                  if (bad_run + BCW'(1) == BCW'(BAD_LIMIT)) begin
                    state   <= S_SLEEP;
                    bad_run <= '0;
                  end else begin
                    bad_run <= bad_run + BCW'(1);
                  end
                end
              end
            end else if (width != '1) begin
              width <= width + WCW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_rx     = state == S_RX;
  assign st_sleep  = state == S_SLEEP;
  assign st_poll   = state == S_POLL;
  assign power_req = !st_sleep;
  assign data_out  = st_rx & raw_data;
endmodule

// File: rtl/poll_wake_checker_sva.sv
module poll_wake_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic sleep_tick,
  input logic raw_data,
  input logic raw_q,
  input logic poll_en_q,
  input logic data_out,
  input logic power_req,
  input logic st_sleep,
  input logic st_poll,
  input logic st_rx
);
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n) $countones({st_sleep, st_poll, st_rx}) == 1); // R9
  AST_DISABLED_RX: assert property (@(posedge clk) disable iff (!rst_n) !poll_en_q |-> st_rx && power_req); // R1
  AST_WAKE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(st_poll) |-> $past(sleep_tick) && !$past(cfg_wr)); // R2
  AST_POLL_GATED: assert property (@(posedge clk) disable iff (!rst_n) (st_poll || st_sleep) |-> !data_out); // R4
  AST_NO_EDGE_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) (st_poll && !cfg_wr && raw_data == raw_q) |=> st_poll); // R5
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (st_rx && !cfg_wr) |=> st_rx); // R7
endmodule

bind poll_wake_checker poll_wake_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .sleep_tick(sleep_tick),
  .raw_data(raw_data), .raw_q(raw_q), .poll_en_q(poll_en_q),
  .data_out(data_out), .power_req(power_req),
  .st_sleep(st_sleep), .st_poll(st_poll), .st_rx(st_rx)
);

// File: tb/tb_poll_wake_checker.sv
module tb_poll_wake_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_tick = 0, cfg_wr = 0, cfg_poll_en = 0, raw_data = 0;
  logic [2:0] cfg_sleep_code = 0, cfg_win_code = 0;
  logic [1:0] cfg_bw_code = 0, cfg_run_code = 0;
  logic data_out, power_req, st_sleep, st_poll, st_rx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  poll_wake_checker dut (
    .clk(clk), .rst_n(rst_n), .sleep_tick(sleep_tick), .cfg_wr(cfg_wr),
    .cfg_poll_en(cfg_poll_en), .cfg_sleep_code(cfg_sleep_code),
    .cfg_win_code(cfg_win_code), .cfg_bw_code(cfg_bw_code),
    .cfg_run_code(cfg_run_code), .raw_data(raw_data), .data_out(data_out),
    .power_req(power_req), .st_sleep(st_sleep), .st_poll(st_poll), .st_rx(st_rx)
  );

  function automatic int win_of(int wc, int bw);
    return (60 - wc * 4) >> bw;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(bit en, int sc, int wc, int bw, int rc);
    @(negedge clk);
    cfg_poll_en = en; cfg_sleep_code = 3'(sc); cfg_win_code = 3'(wc);
    cfg_bw_code = 2'(bw); cfg_run_code = 2'(rc); cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic tick();
    @(negedge clk); sleep_tick = 1;
    @(negedge clk); sleep_tick = 0;
  endtask

  task automatic send(int w);
    @(negedge clk); raw_data = ~raw_data;
    repeat (w - 1) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); raw_data = 1; #1;
    chk("R1 reset rx", st_rx, 1);
    chk("R1 reset power", power_req, 1);
    chk("R1 reset data follows", data_out, 1);
  endtask

  task automatic t_disabled();
    cfg(0, 0, 7, 3, 1);
    repeat (3) tick();
    chk("R1 disabled stays rx", st_rx, 1);
    chk("R9 write without poll -> rx", st_sleep, 0);
  endtask

  task automatic t_sleep_len();
    cfg(1, 3, 7, 3, 1);
    chk("R9 write with poll -> sleep", st_sleep, 1);
    chk("R2 power off in sleep", power_req, 0);
    raw_data = 1; #1;
    chk("R4 data low in sleep", data_out, 0);
    repeat (7) tick();
    chk("R2 still asleep after 7 of 8 ticks", st_sleep, 1);
    tick();
    chk("R2 polling after 8th tick", st_poll, 1);
    chk("R2 power on in poll", power_req, 1);
  endtask

  task automatic wake(int wc, int bw, int rc);
    cfg(1, 0, wc, bw, rc);
    tick();
  endtask

  task automatic t_bad_to_sleep();
    wake(7, 3, 1);
    send(2); send(2); send(2); send(2);
    chk("R10 first edge not graded", st_poll, 1);
    @(negedge clk); #1;
    chk("R4 data low in poll", data_out, 0);
    send(2);
    chk("R5 four bad -> sleep", st_sleep, 1);
  endtask

  task automatic t_valid_release(int wc, int bw);
    int w = win_of(wc, bw);
    wake(wc, bw, 1);
    send(w + 1); repeat (3) send(w + 1);
    chk("R6 three valid still polling", st_poll, 1);
    send(w + 1);
    chk("R3 width window+1 valid, R6 release", st_rx, 1);
    #1; chk("R7 data follows raw", data_out, int'(raw_data));
  endtask

  task automatic t_equal_bad(int wc, int bw);
    int w = win_of(wc, bw);
    wake(wc, bw, 1);
    send(w); repeat (4) send(w);
    chk("R3 width equal window is bad", st_sleep, 1);
  endtask

  task automatic t_sticky();
    repeat (200) @(negedge clk);
    chk("R7 rx sticky on idle", st_rx, 1);
    raw_data = ~raw_data; #1;
    chk("R7 data tracks", data_out, int'(raw_data));
  endtask

  task automatic t_run_resets();
    wake(7, 3, 1);
    send(5); send(5); send(5); send(2); send(5);
    send(5); send(5); send(5);
    chk("R8 bad clears valid run", st_poll, 1);
    send(5);
    chk("R8 release after fresh four", st_rx, 1);
    wake(7, 3, 1);
    send(2); send(2); send(2); send(5); send(2);
    send(2); send(2); send(2);
    chk("R8 valid clears bad run", st_poll, 1);
    send(2);
    chk("R5 sleep after fresh four bad", st_sleep, 1);
  endtask

  task automatic t_run_zero();
    wake(7, 3, 0);
    chk("R6 code 0 wakes into rx", st_rx, 1);
  endtask

  task automatic t_rearm();
    cfg(1, 0, 7, 3, 1);
    chk("R9 rewrite from rx rearms", st_sleep, 1);
    raw_data = 1; #1;
    chk("R4 data low after rearm", data_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_sleep_len();
    t_bad_to_sleep();
    t_valid_release(7, 3);
    t_sticky();
    t_equal_bad(7, 3);
    t_valid_release(0, 1);
    t_equal_bad(0, 1);
    t_run_resets();
    t_run_zero();
    t_rearm();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired, R1 to R10 incomplete actual=hang expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule